// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block sits between a processor's load/store stage and a 32-bit, byte-addressable memory bus whose transfers are always whole aligned words. A request from the processor carries a byte address, an access size, a direction, a sign-extension choice and (for stores) right-justified data. The unit turns it into one bus transfer: the address with its two low bits cleared, a byte-enable mask naming the lanes touched, and store data moved onto those lanes. For loads it picks the addressed bytes out of the returned word, right-justifies them and zero- or sign-extends the result.

Lane order is chosen per request by a plain endian input sampled when the request is accepted. With it low (the default, big-endian), the lowest byte address of a word sits in data bits 31:24; with it high, that byte sits in bits 7:0. An access that breaks natural alignment, or that uses the reserved size code, never reaches the bus: it is answered at once with an error flag.

The processor side is two valid/ready streams. A request moves when `req_valid` and `req_ready` are both high on a clock edge; `req_ready` is high only when the unit is idle, so one access is in flight at a time. A response stays presented, unchanged, until `rsp_ready` is high on an edge, and the next request is not taken before then. The bus side is a request/acknowledge handshake in which the unit holds every bus output steady until `bus_ack` is seen.

Top module: `lsu_lane_align`

## Requirements
- R1: While `bus_req` is high, `bus_addr` equals the accepted byte address with bits 1:0 forced to zero.
- R2: Size code 0 (byte) enables exactly one lane, code 1 (halfword) two adjacent lanes, code 2 (word) all four. `bus_be[i]` enables data bits 8i+7:8i. In big-endian mode, byte offset k within the word uses lane 3-k; in little-endian mode it uses lane k.
- R3: In big-endian mode, store data is placed so that the most significant byte of the value lands at the lowest byte address of the access. Lanes that are not enabled carry zero.
- R4: In little-endian mode, store data is placed so that the least significant byte of the value lands at the lowest byte address of the access. Lanes that are not enabled carry zero.
- R5: A halfword at an odd address, a word at an address not divisible by 4, or size code 3 yields a response with `rsp_misalign` high and `rsp_data` zero, and `bus_req` is never raised for it.
- R6: A load returns the addressed value right-justified in `rsp_data`. With `req_signed` low the upper bits are zero. A store returns `rsp_data` zero with `rsp_misalign` low.
- R7: A byte or halfword load with `req_signed` high copies the value's top bit into all upper bits of `rsp_data`.
- R8: Once `bus_req` rises it stays high, and `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` stay unchanged, until the cycle in which `bus_ack` is high.
- R9: `req_ready` is low from acceptance until the response is taken. `rsp_valid`, `rsp_data` and `rsp_misalign` stay unchanged while `rsp_ready` is low.
- R10: After reset, `req_ready` is high and `bus_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend load result when high |
| req_wdata | input | 32 | Right-justified store value |
| little_endian | input | 1 | 0 big-endian lane order, 1 little-endian |
| bus_req | output | 1 | Bus transfer requested |
| bus_ack | input | 1 | Bus transfer complete; read data valid |
| bus_we | output | 1 | Bus write strobe |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Per-lane byte enables |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data, sampled with `bus_ack` |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_data | output | 32 | Extended load value, zero for stores and errors |
| rsp_misalign | output | 1 | Access rejected for alignment or size |

## Verification
The bench walks every byte offset for every size in both lane orders, since a design with the big-endian shift mirrored would enable lane k instead of 3-k and put halfwords in the wrong half of the word. Loads of values with their top bit set are issued with and without sign extension, so an off-by-one on the top-byte lane would extend from the wrong bit and an ignored sign input would show as zeros in the upper bits. Misaligned halfwords and words and the reserved size are sent to confirm no bus transfer appears; a design that filtered only on the bus side would raise `bus_req` and return bus data. Bus acknowledge and response acceptance are both delayed by random counts to catch outputs that move before their handshake completes.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RSP  = 2'd2
  } lsu_state_e;

  localparam int unsigned SIZE_W = 2;

endpackage

// File: rtl/lane_plan.sv
// Decides which lanes an access touches and how far the value is shifted.
module lane_plan #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic              little_endian,
  output logic [LANES-1:0]  be,
  output logic [OFF_W-1:0]  shift,
  output logic              misalign
);

  int nb_i;
  int sh_i;
  logic size_ok;

  always_comb begin
    size_ok  = (int'(size) <= int'(OFF_W));
    nb_i     = size_ok ? (1 << size) : int'(LANES);
    misalign = !size_ok || ((int'(off) & (nb_i - 1)) != 0);
    if (little_endian) sh_i = int'(off);
    else               sh_i = int'(LANES) - nb_i - int'(off);
    if (misalign) sh_i = 0;
    shift = OFF_W'(sh_i);
    if (misalign) be = '0;
    else          be = LANES'(((1 << nb_i) - 1) << sh_i);
  end

endmodule

// File: rtl/store_steer.sv
// Moves a right-justified store value onto the enabled lanes.
module store_steer #(
  parameter int unsigned LANES = 4,
  parameter int unsigned OFF_W = 2
) (
  input  logic [8*LANES-1:0] value,
  input  logic [OFF_W-1:0]   shift,
  input  logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] lanes
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W:0] src;
    assign src = (OFF_W + 1)'(i) - {1'b0, shift};
    assign lanes[8*i +: 8] = be[i] ? value[{src[OFF_W-1:0], 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/load_extract.sv
// Picks the addressed bytes out of a bus word and extends them.
module load_extract #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [8*LANES-1:0] word,
  input  logic [OFF_W-1:0]   shift,
  input  logic [SIZE_W-1:0]  size,
  input  logic               sign_ext,
  output logic [8*LANES-1:0] value
);

  int nb_i;
  logic [OFF_W-1:0] top_lane;
  logic top_bit;
  logic [7:0] fill;

  always_comb begin
    nb_i     = (int'(size) <= int'(OFF_W)) ? (1 << size) : int'(LANES);
    top_lane = OFF_W'(int'(shift) + nb_i - 1);
    top_bit  = word[{top_lane, 3'b111}];
    fill     = (sign_ext && top_bit) ? 8'hFF : 8'h00;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [OFF_W-1:0] lane;
    assign lane = OFF_W'(k) + shift;
    assign value[8*k +: 8] = (k < nb_i) ? word[{lane, 3'b000} +: 8] : fill;
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              little_endian,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_misalign
);
  import lane_align_pkg::*;

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  lsu_state_e state_q;

  logic [LANES-1:0]  plan_be;
  logic [OFF_W-1:0]  plan_shift;
  logic              plan_mis;
  logic [DATA_W-1:0] steered;
  logic [DATA_W-1:0] loaded;

  logic [OFF_W-1:0]  shift_q;
  logic [SIZE_W-1:0] size_q;
  logic              sign_q;
  logic              accept;

  lane_plan #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_plan (
    .off          (req_addr[OFF_W-1:0]),
    .size         (req_size),
    .little_endian(little_endian),
    .be           (plan_be),
    .shift        (plan_shift),
    .misalign     (plan_mis)
  );

  store_steer #(.LANES(LANES), .OFF_W(OFF_W)) u_steer (
    .value(req_wdata),
    .shift(plan_shift),
    .be   (plan_be),
    .lanes(steered)
  );

  load_extract #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_extract (
    .word    (bus_rdata),
    .shift   (shift_q),
    .size    (size_q),
    .sign_ext(sign_q),
    .value   (loaded)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign bus_req   = (state_q == ST_BUS);
  assign rsp_valid = (state_q == ST_RSP);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      bus_addr     <= '0;
      bus_be       <= '0;
      bus_we       <= 1'b0;
      bus_wdata    <= '0;
      shift_q      <= '0;
      size_q       <= '0;
      sign_q       <= 1'b0;
      rsp_data     <= '0;
      rsp_misalign <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          bus_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          bus_be    <= plan_be;
          bus_we    <= req_write;
          bus_wdata <= req_write ? steered : '0;
          shift_q   <= plan_shift;
          size_q    <= req_size;
          sign_q    <= req_signed;
          if (plan_mis) begin
            rsp_data     <= '0;
            rsp_misalign <= 1'b1;
            state_q      <= ST_RSP;
          end else begin
            state_q <= ST_BUS;
          end
        end
        ST_BUS: if (bus_ack) begin
          rsp_data     <= bus_we ? '0 : loaded;
          rsp_misalign <= 1'b0;
          state_q      <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Bus outputs frozen until acknowledge (R8)
  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be)
                            && $stable(bus_we) && $stable(bus_wdata));

  // Word-aligned address on the bus (R1)
  assert_bus_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[OFF_W-1:0] == '0);

  // Lane count is a power of two for every issued transfer (R2)
  assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2
                 || $countones(bus_be) == LANES));

  // Rejected access never occupies the bus (R5)
  assert_mis_no_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misalign |-> !bus_req && rsp_data == '0);

  // Response held under back-pressure (R9)
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_misalign));

  // No new request taken while one is outstanding (R9)
  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req && !rsp_valid);

endmodule

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_signed = 0, little_endian = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_size = 0;
  logic        req_ready;
  logic        bus_req, bus_ack = 0, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [3:0]  bus_be;
  logic        rsp_valid, rsp_ready = 0, rsp_misalign;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lsu_lane_align u_lsu_lane_align (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
    .req_wdata(req_wdata), .little_endian(little_endian),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_misalign(rsp_misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit is_mis(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd3) return 1;
    return (a % nbytes(sz)) != 0;
  endfunction

  function automatic int lane_of(input bit le, input int off);
    return le ? off : 3 - off;
  endfunction

  // value byte index carried by address byte b of the access
  function automatic int vbyte(input bit le, input int n, input int b);
    return le ? b : n - 1 - b;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [31:0] a, input bit le);
    logic [3:0] m = 0;
    for (int b = 0; b < nbytes(sz); b++) m[lane_of(le, int'(a[1:0]) + b)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] a,
                                         input bit le, input logic [31:0] v);
    logic [31:0] w = 0;
    int n = nbytes(sz);
    for (int b = 0; b < n; b++)
      w[8*lane_of(le, int'(a[1:0]) + b) +: 8] = v[8*vbyte(le, n, b) +: 8];
    return w;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [31:0] a,
                                         input bit le, input bit sgn, input logic [31:0] w);
    logic [31:0] v = 0;
    int n = nbytes(sz);
    for (int b = 0; b < n; b++)
      v[8*vbyte(le, n, b) +: 8] = w[8*lane_of(le, int'(a[1:0]) + b) +: 8];
    if (sgn && n < 4 && v[8*n-1]) for (int i = 8*n; i < 32; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic txn(input bit wr, input logic [31:0] a, input logic [1:0] sz, input bit sgn,
                     input bit le, input logic [31:0] wd, input logic [31:0] rd,
                     input int ack_lat, input int rsp_lat);
    bit mis = is_mis(sz, a);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz;
    req_signed = sgn; little_endian = le; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; little_endian = ~le;
    chk("R9 ready low after accept", req_ready, 0);
    if (mis) begin
      chk("R5 no bus request", bus_req, 0);
      chk("R5 misalign flag", {rsp_valid, rsp_misalign}, 2'b11);
      chk("R5 data zero", rsp_data, 0);
    end else begin
      for (int c = 0; c <= ack_lat; c++) begin
        if (c > 0) @(negedge clk);
        chk("R8 req held", bus_req, 1);
        chk("R1 bus address", bus_addr, {a[31:2], 2'b00});
        chk("R2 byte enables", bus_be, exp_be(sz, a, le));
        chk("R8 write strobe", bus_we, wr);
        if (wr) chk(le ? "R4 store lanes" : "R3 store lanes", bus_wdata, exp_wd(sz, a, le, wd));
      end
      bus_ack = 1; bus_rdata = rd;
      @(posedge clk);
      @(negedge clk);
      bus_ack = 0; bus_rdata = $urandom;
      chk("R9 response valid", rsp_valid, 1);
      chk("R6 misalign low", rsp_misalign, 0);
      chk("R5 bus released", bus_req, 0);
      if (wr) chk("R6 store rsp zero", rsp_data, 0);
      else chk(sgn ? "R7 signed load" : "R6 zero-extended load", rsp_data,
               exp_ld(sz, a, le, sgn, rd));
    end
    for (int c = 0; c < rsp_lat; c++) begin
      @(negedge clk);
      chk("R9 rsp held", {rsp_valid, rsp_misalign}, {1'b1, mis});
      if (mis) chk("R9 rsp data held", rsp_data, 0);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    chk("R9 ready after response", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20151211));
    repeat (3) @(negedge clk);
    chk("R10 reset ready", req_ready, 1);
    chk("R10 reset bus_req", bus_req, 0);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle after reset", {req_ready, bus_req, rsp_valid}, 3'b100);

    // Directed: every offset/size in both lane orders, stores then loads
    for (int le = 0; le < 2; le++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++) begin
          txn(1, 32'h1000_0000 + off, 2'(sz), 0, le[0], 32'hA1B2C3D4, 0, 0, 0);
          txn(0, 32'h2000_0000 + off, 2'(sz), 1, le[0], 0, 32'h8899F0E1, 1, 1);
          txn(0, 32'h2000_0000 + off, 2'(sz), 0, le[0], 0, 32'h8899F0E1, 0, 0);
        end
    // Directed misaligned and reserved-size cases
    txn(0, 32'h0000_0001, 2'd1, 0, 0, 0, 32'hFFFFFFFF, 0, 2);
    txn(1, 32'h0000_0003, 2'd1, 0, 1, 32'h1234, 0, 0, 0);
    txn(0, 32'h0000_0002, 2'd2, 1, 0, 0, 0, 0, 1);
    txn(1, 32'h0000_0004, 2'd3, 0, 0, 32'h55, 0, 0, 0);
    // Directed positive-value signed loads stay zero in upper bits
    txn(0, 32'h30, 2'd0, 1, 0, 0, 32'h7F000000, 2, 0);
    txn(0, 32'h32, 2'd1, 1, 1, 0, 32'h7FFF0000, 0, 0);

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a = $urandom;
      logic [1:0] sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0 && sz != 2'd3) begin
        if (sz == 2'd1) a[0] = 0;
        if (sz == 2'd2) a[1:0] = 0;
      end
      txn($urandom_range(0, 1) != 0, a, sz, $urandom_range(0, 1) != 0,
          $urandom_range(0, 1) != 0, $urandom, $urandom,
          $urandom_range(0, 4), $urandom_range(0, 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule